// File: doc/BRIEF.md
# Issue Slot Waste Accounting Unit

This block watches an issue stage that can launch up to eight instructions per cycle and keeps running totals of how that issue bandwidth was spent. On each cycle that carries a valid sample, the pipeline reports how many slots it filled and a 4-bit stall cause. Filled slots go to a busy total. Empty slots are first classified as vertical waste, when the whole cycle issued nothing, or horizontal waste, when the cycle was only partly filled. The same empty slots are also charged, all together, to the single stall cause the pipeline named for that cycle. That cause is the one that held back the next instruction longest.

Counters saturate instead of wrapping, so a long run never shows a small, misleading total. A synchronous clear zeroes every counter at once, which lets a measurement window be opened at any chosen cycle. All totals are driven continuously on output ports for whatever readout logic sits around the block.

Top module: `slot_waste_acct`

## Requirements
- R1: On a sampled cycle, the busy counter grows by the number of filled slots.
- R2: A sampled cycle with zero filled slots adds SLOTS (8) to the vertical counter and leaves the horizontal counter unchanged.
- R3: A sampled cycle with between 1 and SLOTS-1 filled slots adds SLOTS minus the filled count to the horizontal counter and leaves the vertical counter unchanged.
- R4: A sampled cycle with all SLOTS filled changes neither waste counter nor any cause counter.
- R5: All empty slots of a sampled cycle are added to exactly one cause counter, chosen by the cause code. Codes 0 to 11 select bins 0 to 11 in this order: memory conflict, long FP, short FP, long integer, short integer, load delay, control hazard, branch misprediction, data-cache miss, instruction-cache miss, data-TLB miss, instruction-TLB miss. Bin i is read at cause_cnt[i*CNT_W +: CNT_W].
- R6: Codes 12 to 15 are charged to the reserved "other" bin, index 12.
- R7: When sample_vld is low, no counter changes.
- R8: When clear is high, every counter reads zero after that clock edge, and a sample presented in the same cycle is dropped.
- R9: Every counter stops at all ones and never wraps.
- R10: An issued value above SLOTS is treated as SLOTS filled.
- R11: After reset, every counter reads zero.
- R12: Until any of busy, vertical or horizontal saturates, their sum equals SLOTS times the number of sampled cycles since reset or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | This cycle's issue report is valid |
| issued | input | 4 | Number of slots filled this cycle |
| cause_code | input | 4 | Stall cause charged with this cycle's empty slots |
| clear | input | 1 | Synchronous clear of all counters |
| busy_cnt | output | CNT_W | Filled-slot total |
| vert_cnt | output | CNT_W | Empty slots from fully idle cycles |
| horiz_cnt | output | CNT_W | Empty slots from partly filled cycles |
| cause_cnt | output | 13*CNT_W | Per-cause empty-slot totals, bin i at bits i*CNT_W |

## Verification
The bench builds the block with SLOTS at 8 and CNT_W reduced to 8. With 8-bit counters, a few dozen full or idle cycles drive the busy, vertical and per-cause totals into saturation, so the clamp at all ones can be observed directly. The same runs cover the per-cycle arithmetic for every cause code, including the four codes that fall into the reserved bin. The slot-total identity is checked over a mixed pattern of cycles that stays below the saturation point.

// File: rtl/slot_waste_pkg.sv
package slot_waste_pkg;

  // Number of named stall causes; one more bin collects undefined codes.
  localparam int NUM_NAMED_CAUSES = 12;

  typedef enum logic [3:0] {
    STALL_MEM_CONFLICT = 4'd0,
    STALL_FP_LONG      = 4'd1,
    STALL_FP_SHORT     = 4'd2,
    STALL_INT_LONG     = 4'd3,
    STALL_INT_SHORT    = 4'd4,
    STALL_LOAD_DELAY   = 4'd5,
    STALL_CTRL_HAZARD  = 4'd6,
    STALL_BR_MISPRED   = 4'd7,
    STALL_DC_MISS      = 4'd8,
    STALL_IC_MISS      = 4'd9,
    STALL_DTLB_MISS    = 4'd10,
    STALL_ITLB_MISS    = 4'd11
  } stall_cause_e;

endpackage

// File: rtl/swa_slot_split.sv
// Splits one issue report into busy and waste increments.
module swa_slot_split #(
  parameter int SLOTS = 8,
  parameter int INC_W = $clog2(SLOTS + 1)
) (
  input  logic [INC_W-1:0] issued,
  output logic [INC_W-1:0] busy_inc,
  output logic [INC_W-1:0] vert_inc,
  output logic [INC_W-1:0] horiz_inc,
  output logic [INC_W-1:0] waste_inc
);

  localparam logic [INC_W-1:0] FULL = INC_W'(SLOTS);

  logic [INC_W-1:0] filled;

  always_comb begin
    filled = (issued > FULL) ? FULL : issued;
    busy_inc  = filled;
    waste_inc = FULL - filled;
    if (filled == '0) begin
      vert_inc  = FULL;
      horiz_inc = '0;
    end else begin
      vert_inc  = '0;
      horiz_inc = FULL - filled;
    end
  end

endmodule

// File: rtl/swa_cause_sel.sv
// Turns a cause code into a one-hot bin select; unnamed codes use the last bin.
module swa_cause_sel #(
  parameter int CAUSE_W  = 4,
  parameter int NUM_NAMED = 12,
  parameter int NUM_BINS = NUM_NAMED + 1
) (
  input  logic [CAUSE_W-1:0]  code,
  output logic [NUM_BINS-1:0] sel
);

  localparam logic [CAUSE_W-1:0] FIRST_OTHER = CAUSE_W'(NUM_NAMED);

  for (genvar gi = 0; gi < NUM_NAMED; gi++) begin : g_named
    assign sel[gi] = (code == CAUSE_W'(gi));
  end

  assign sel[NUM_NAMED] = (code >= FIRST_OTHER);

endmodule

// File: rtl/swa_sat_ctr.sv
// Saturating accumulator with synchronous clear and explicit load enable.
module swa_sat_ctr #(
  parameter int CNT_W = 32,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   sum;
  logic             ld;

  always_comb begin
    sum   = {1'b0, cnt_q} + (CNT_W + 1)'(inc);
    ld    = clr | en;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/slot_waste_acct.sv
module slot_waste_acct #(
  parameter int SLOTS     = 8,
  parameter int CNT_W     = 32,
  parameter int CAUSE_W   = 4,
  parameter int NUM_NAMED = slot_waste_pkg::NUM_NAMED_CAUSES,
  parameter int ISS_W     = $clog2(SLOTS + 1),
  parameter int NUM_BINS  = NUM_NAMED + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sample_vld,
  input  logic [ISS_W-1:0]          issued,
  input  logic [CAUSE_W-1:0]        cause_code,
  input  logic                      clear,
  output logic [CNT_W-1:0]          busy_cnt,
  output logic [CNT_W-1:0]          vert_cnt,
  output logic [CNT_W-1:0]          horiz_cnt,
  output logic [NUM_BINS*CNT_W-1:0] cause_cnt
);

  logic                take;
  logic [ISS_W-1:0]    busy_inc;
  logic [ISS_W-1:0]    vert_inc;
  logic [ISS_W-1:0]    horiz_inc;
  logic [ISS_W-1:0]    waste_inc;
  logic [NUM_BINS-1:0] bin_sel;

  // A clear in the same cycle wins over the sample.
  assign take = sample_vld & ~clear;

  swa_slot_split #(.SLOTS(SLOTS), .INC_W(ISS_W)) u_split (
    .issued    (issued),
    .busy_inc  (busy_inc),
    .vert_inc  (vert_inc),
    .horiz_inc (horiz_inc),
    .waste_inc (waste_inc)
  );

  swa_cause_sel #(.CAUSE_W(CAUSE_W), .NUM_NAMED(NUM_NAMED), .NUM_BINS(NUM_BINS)) u_sel (
    .code (cause_code),
    .sel  (bin_sel)
  );

  swa_sat_ctr #(.CNT_W(CNT_W), .INC_W(ISS_W)) u_busy (
    .clk (clk), .rst_n (rst_n), .clr (clear),
    .en  (take & (busy_inc != '0)), .inc (busy_inc), .cnt (busy_cnt)
  );

  swa_sat_ctr #(.CNT_W(CNT_W), .INC_W(ISS_W)) u_vert (
    .clk (clk), .rst_n (rst_n), .clr (clear),
    .en  (take & (vert_inc != '0)), .inc (vert_inc), .cnt (vert_cnt)
  );

  swa_sat_ctr #(.CNT_W(CNT_W), .INC_W(ISS_W)) u_horiz (
    .clk (clk), .rst_n (rst_n), .clr (clear),
    .en  (take & (horiz_inc != '0)), .inc (horiz_inc), .cnt (horiz_cnt)
  );

  for (genvar gb = 0; gb < NUM_BINS; gb++) begin : g_bin
    swa_sat_ctr #(.CNT_W(CNT_W), .INC_W(ISS_W)) u_bin (
      .clk (clk), .rst_n (rst_n), .clr (clear),
      .en  (take & bin_sel[gb] & (waste_inc != '0)),
      .inc (waste_inc),
      .cnt (cause_cnt[gb*CNT_W +: CNT_W])
    );
  end

endmodule

// File: rtl/slot_waste_acct_chk.sv
module slot_waste_acct_chk #(
  parameter int SLOTS     = 8,
  parameter int CNT_W     = 32,
  parameter int CAUSE_W   = 4,
  parameter int NUM_NAMED = 12,
  parameter int ISS_W     = 4,
  parameter int NUM_BINS  = 13
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sample_vld,
  input logic [ISS_W-1:0]          issued,
  input logic [CAUSE_W-1:0]        cause_code,
  input logic                      clear,
  input logic [CNT_W-1:0]          busy_cnt,
  input logic [CNT_W-1:0]          vert_cnt,
  input logic [CNT_W-1:0]          horiz_cnt,
  input logic [NUM_BINS*CNT_W-1:0] cause_cnt
);

  localparam int SMP_W = CNT_W + 8;
  localparam int CMP_W = SMP_W + 8;
  localparam logic [CNT_W-1:0] ROOM = '1 - CNT_W'(SLOTS);
  localparam logic [ISS_W-1:0] FULL = ISS_W'(SLOTS);

  logic [SMP_W-1:0] samples_q;
  logic             sat_q;
  logic             any_sat;
  logic [CMP_W-1:0] slot_sum;
  logic [CMP_W-1:0] slot_exp;
  logic [CNT_W-1:0] bin0;
  logic [CNT_W-1:0] bin_other;

  assign bin0      = cause_cnt[0 +: CNT_W];
  assign bin_other = cause_cnt[NUM_NAMED*CNT_W +: CNT_W];
  assign any_sat   = (busy_cnt == '1) | (vert_cnt == '1) | (horiz_cnt == '1);
  assign slot_sum  = CMP_W'(busy_cnt) + CMP_W'(vert_cnt) + CMP_W'(horiz_cnt);
  assign slot_exp  = CMP_W'(samples_q) * CMP_W'(SLOTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samples_q <= '0;
      sat_q     <= 1'b0;
    end else if (clear) begin
      samples_q <= '0;
      sat_q     <= 1'b0;
    end else begin
      if (sample_vld && !sat_q) samples_q <= samples_q + 1'b1;
      if (any_sat) sat_q <= 1'b1;
    end
  end

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_vld && !clear) |=> ($stable(busy_cnt) && $stable(vert_cnt)
                                 && $stable(horiz_cnt) && $stable(cause_cnt)));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (busy_cnt == '0 && vert_cnt == '0 && horiz_cnt == '0 && cause_cnt == '0));

  a_r4_full_no_waste: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !clear && issued >= FULL)
      |=> ($stable(vert_cnt) && $stable(horiz_cnt) && $stable(cause_cnt)));

  a_r2_idle_vertical: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !clear && issued == '0 && vert_cnt <= ROOM)
      |=> (vert_cnt == $past(vert_cnt) + CNT_W'(SLOTS) && $stable(horiz_cnt)));

  a_r5_bin0_charge: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !clear && issued == '0 && cause_code == '0 && bin0 <= ROOM)
      |=> (cause_cnt[0 +: CNT_W] == $past(bin0) + CNT_W'(SLOTS)));

  a_r6_other_charge: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !clear && issued == '0 && cause_code >= CAUSE_W'(NUM_NAMED)
     && bin_other <= ROOM)
      |=> (cause_cnt[NUM_NAMED*CNT_W +: CNT_W] == $past(bin_other) + CNT_W'(SLOTS)));

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (busy_cnt >= $past(busy_cnt) && vert_cnt >= $past(vert_cnt)
                && horiz_cnt >= $past(horiz_cnt)));

  a_r12_slot_total: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_q && !any_sat) |-> (slot_sum == slot_exp));

endmodule

bind slot_waste_acct slot_waste_acct_chk #(
  .SLOTS(SLOTS), .CNT_W(CNT_W), .CAUSE_W(CAUSE_W),
  .NUM_NAMED(NUM_NAMED), .ISS_W(ISS_W), .NUM_BINS(NUM_BINS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .issued(issued),
  .cause_code(cause_code), .clear(clear), .busy_cnt(busy_cnt),
  .vert_cnt(vert_cnt), .horiz_cnt(horiz_cnt), .cause_cnt(cause_cnt)
);

// File: tb/slot_waste_acct_tb.sv
`timescale 1ns/1ps
module slot_waste_acct_tb;

  localparam int SLOTS = 8;
  localparam int CW    = 8;
  localparam int BINS  = 13;
  localparam int MAXV  = (1 << CW) - 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            sample_vld;
  logic [3:0]      issued;
  logic [3:0]      cause_code;
  logic            clear;
  logic [CW-1:0]   busy_cnt, vert_cnt, horiz_cnt;
  logic [BINS*CW-1:0] cause_cnt;

  int total = 0;
  int bad   = 0;
  int e_busy, e_vert, e_horiz, n_smp;
  int e_bin[BINS];

  always #2 clk = ~clk;

  slot_waste_acct #(.SLOTS(SLOTS), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .issued(issued),
    .cause_code(cause_code), .clear(clear), .busy_cnt(busy_cnt),
    .vert_cnt(vert_cnt), .horiz_cnt(horiz_cnt), .cause_cnt(cause_cnt)
  );

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "busy", int'(busy_cnt), e_busy);
    chk(req, "vert", int'(vert_cnt), e_vert);
    chk(req, "horiz", int'(horiz_cnt), e_horiz);
    for (int i = 0; i < BINS; i++)
      chk(req, $sformatf("bin%0d", i), int'(cause_cnt[i*CW +: CW]), e_bin[i]);
  endtask

  task automatic model_zero();
    e_busy = 0; e_vert = 0; e_horiz = 0; n_smp = 0;
    for (int i = 0; i < BINS; i++) e_bin[i] = 0;
  endtask

  // One clock with the given inputs; the expected totals follow the requirements.
  task automatic step(input bit v, input int iss, input int code, input bit clr);
    int f;
    int b;
    @(negedge clk);
    sample_vld = v; issued = iss[3:0]; cause_code = code[3:0]; clear = clr;
    @(posedge clk);
    #1;
    if (clr) begin
      model_zero();
    end else if (v) begin
      n_smp++;
      f = (iss > SLOTS) ? SLOTS : iss;
      e_busy = sat(e_busy + f);
      if (f == 0) e_vert = sat(e_vert + SLOTS);
      else if (f < SLOTS) e_horiz = sat(e_horiz + SLOTS - f);
      if (f < SLOTS) begin
        b = (code >= 12) ? 12 : code;
        e_bin[b] = sat(e_bin[b] + SLOTS - f);
      end
    end
    @(negedge clk);
    sample_vld = 1'b0; clear = 1'b0;
  endtask

  task automatic t_reset();   // R11
    model_zero();
    check_all("R11");
  endtask

  task automatic t_full();    // R1, R4
    step(1, 8, 3, 0);
    step(1, 8, 7, 0);
    check_all("R4");
    chk("R1", "busy after two full", int'(busy_cnt), 16);
  endtask

  task automatic t_idle();    // R2
    step(1, 0, 5, 0);
    check_all("R2");
    chk("R2", "vert single idle", int'(vert_cnt), 8);
  endtask

  task automatic t_partial(); // R3, R1
    step(1, 3, 2, 0);
    check_all("R3");
    step(1, 7, 9, 0);
    step(1, 1, 9, 0);
    check_all("R3");
    chk("R1", "busy partial", int'(busy_cnt), 16 + 3 + 7 + 1);
  endtask

  task automatic t_causes();  // R5
    step(0, 0, 0, 1);
    for (int c = 0; c < 12; c++) step(1, c % 8, c, 0);
    check_all("R5");
  endtask

  task automatic t_other();   // R6
    step(0, 0, 0, 1);
    for (int c = 12; c < 16; c++) step(1, 2, c, 0);
    check_all("R6");
    chk("R6", "other bin", int'(cause_cnt[12*CW +: CW]), 24);
  endtask

  task automatic t_novalid(); // R7
    step(1, 4, 1, 0);
    step(0, 0, 1, 0);
    step(0, 5, 12, 0);
    check_all("R7");
  endtask

  task automatic t_clear();   // R8
    step(1, 2, 4, 0);
    step(1, 0, 4, 1);
    check_all("R8");
    chk("R8", "vert after clear", int'(vert_cnt), 0);
  endtask

  task automatic t_clamp();   // R10
    step(0, 0, 0, 1);
    step(1, 13, 6, 0);
    step(1, 15, 6, 0);
    check_all("R10");
    chk("R10", "busy clamp", int'(busy_cnt), 16);
  endtask

  task automatic t_invariant(); // R12
    step(0, 0, 0, 1);
    for (int k = 0; k < 20; k++) step(1, (k * 5) % 9, k % 16, 0);
    check_all("R12");
    chk("R12", "slot total", int'(busy_cnt) + int'(vert_cnt) + int'(horiz_cnt), SLOTS * n_smp);
  endtask

  task automatic t_saturate(); // R9
    step(0, 0, 0, 1);
    for (int k = 0; k < 40; k++) step(1, 8, 0, 0);
    for (int k = 0; k < 40; k++) step(1, 0, 10, 0);
    check_all("R9");
    chk("R9", "busy held at max", int'(busy_cnt), MAXV);
    chk("R9", "vert held at max", int'(vert_cnt), MAXV);
    chk("R9", "bin10 held at max", int'(cause_cnt[10*CW +: CW]), MAXV);
  endtask

  initial begin
    rst_n = 1'b0; sample_vld = 1'b0; issued = '0; cause_code = '0; clear = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_full();
    t_idle();
    t_partial();
    t_causes();
    t_other();
    t_novalid();
    t_clear();
    t_clamp();
    t_invariant();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule